// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM of 1M x 8 organisation. The host hands over one word at a time through a request/ready handshake: it presents an address, a write flag and write data, and holds `req` high until a cycle in which `ready` is also high. Reads come back on `rd_data` with a single-cycle `rd_valid` strobe. The controller produces every strobe the RAM needs. It drives an active-low and an active-high chip enable, an active-low write enable, an active-low output enable, the 20-bit address, and the 8-bit data bus. The bus is split into an outgoing value, an incoming value and a drive enable.

Each phase length is a whole number of clock cycles. It is worked out during elaboration as the ceiling of a minimum time in nanoseconds divided by `CLK_PERIOD_NS`, and never less than one cycle. `SPEED_GRADE` (45, 55 or 70) picks which set of minimum times applies. After reset the controller waits `PWRUP_NS` before it accepts a request. When it has no work, it deselects the RAM so that the RAM drops into standby.

The state machine has seven states. PWRUP leaves for IDLE when the power-up wait ends. IDLE goes to READ on a read request and to WSETUP on a write request. READ goes to RTURN on its last cycle, and RTURN returns to IDLE. WSETUP goes to WPULSE, WPULSE to WRECOV, and WRECOV back to IDLE. Every timed state leaves only when its phase counter expires.

Top module: `sram_ctrl`

## Requirements
- R1: After reset is released, `ready` stays low and the RAM stays deselected for ceil(PWRUP_NS/CLK_PERIOD_NS) cycles. `ready` first goes high after exactly that many rising edges (20000 at the defaults).
- R2: Whenever `ready` is high, the controller is idle with `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R3: `mem_oe_n` and `mem_we_n` are never low in the same cycle.
- R4: A read keeps the RAM selected with `mem_oe_n` low and `mem_we_n` high for max(ceil(tRC/T), ceil(tAA/T)) consecutive cycles. At the defaults (45 ns grade, T=10 ns) this is 5 cycles.
- R5: `rd_data` holds the value on `mem_dq_in` at the last read cycle. `rd_valid` is high for exactly one cycle, the first cycle after `mem_oe_n` rises.
- R6: A write selects the RAM for one cycle with `mem_we_n` high and the bus driven. It then holds `mem_we_n` low for max(ceil(tPWE/T), ceil(tAW/T), ceil(tSD/T)) cycles (4 at defaults). Through the whole pulse, `mem_dq_out` is stable and equal to the host write data.
- R7: `mem_dq_oe` is high only while `mem_oe_n` is high.
- R8: After `mem_oe_n` rises, `mem_dq_oe` stays low for at least ceil(15 ns/T) cycles (2 at defaults).
- R9: After a write pulse, the RAM is deselected for max(1, ceil(tWC/T) - 1 - pulse) cycles before `ready` returns. This is 1 cycle at defaults.
- R10: While the RAM is selected, `mem_addr` is stable and equals the address the host gave with the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Host word address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle; request accepted when req is also high |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_addr | output | 20 | RAM address |
| mem_dq_out | output | 8 | Value driven onto the RAM data bus |
| mem_dq_in | input | 8 | Value read from the RAM data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when high |

## Verification
The bench goes after the exact length of every strobe. A phase counter that is off by one would show as a read shorter than the access time or a write pulse shorter than its minimum, and both are reported with their measured lengths. It checks bus turnaround from read to write: a controller that drives the bus while output enable is low, or too soon after it rises, would collide with the RAM's own drivers. It walks the corner addresses 0 and FFFFF, the all-zero and all-one data words, overwrites, and tight alternation of reads and writes. A latch that picks up the host address or data in the wrong cycle, or a read captured one cycle early, returns wrong data to the scoreboard. The power-up hold-off is counted to the exact cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_PWRUP  = 3'd0,
        S_IDLE   = 3'd1,
        S_READ   = 3'd2,
        S_RTURN  = 3'd3,
        S_WSETUP = 3'd4,
        S_WPULSE = 3'd5,
        S_WRECOV = 3'd6
    } state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // ceiling of ns / period, never below one cycle
    function automatic int ns2cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int t_cycle(input int grade);
        case (grade)
            45:      return 45;
            55:      return 55;
            default: return 70;
        endcase
    endfunction

    function automatic int t_wpulse(input int grade);
        case (grade)
            45:      return 35;
            55:      return 40;
            default: return 45;
        endcase
    endfunction

    function automatic int t_sel_to_end(input int grade);
        case (grade)
            45:      return 40;
            55:      return 40;
            default: return 60;
        endcase
    endfunction

    function automatic int t_data_setup(input int grade);
        case (grade)
            45:      return 25;
            55:      return 25;
            default: return 30;
        endcase
    endfunction

    localparam int T_BUS_RELEASE_NS = 15;

endpackage

// File: rtl/sram_ctrl_pwrup.sv
module sram_ctrl_pwrup #(
    parameter int CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sram_ctrl_phase.sv
module sram_ctrl_phase #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    assign last = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end

    AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 45,
    parameter int PWRUP_NS      = 200000,
    parameter int AW            = 20,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          mem_ce_n,
    output logic          mem_ce,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    localparam int T = CLK_PERIOD_NS;
    localparam int RD_CYC  = imax(ns2cyc(t_cycle(SPEED_GRADE), T),
                                  ns2cyc(t_cycle(SPEED_GRADE), T));
    localparam int WSU_CYC = 1;
    localparam int WP_CYC  = imax(ns2cyc(t_wpulse(SPEED_GRADE), T),
                             imax(ns2cyc(t_sel_to_end(SPEED_GRADE), T),
                                  ns2cyc(t_data_setup(SPEED_GRADE), T)));
    localparam int REC_CYC = imax(1, ns2cyc(t_cycle(SPEED_GRADE), T) - WSU_CYC - WP_CYC);
    localparam int HZ_CYC  = ns2cyc(T_BUS_RELEASE_NS, T);
    localparam int PWR_CYC = ns2cyc(PWRUP_NS, T);
    localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, imax(HZ_CYC, WSU_CYC)));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    state_e           state, nxt;
    logic             pw_done;
    logic             ph_last;
    logic             ph_load;
    logic [CNT_W-1:0] ph_len;
    logic             accept;
    logic             capture;
    logic             sel;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;

    sram_ctrl_pwrup #(.CYC(PWR_CYC)) u_pwrup (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pw_done)
    );

    sram_ctrl_phase #(.W(CNT_W)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ph_load),
        .len  (ph_len),
        .last (ph_last)
    );

    sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .host_addr (addr),
        .host_wdata(wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_PWRUP;
        else
            state <= nxt;
    end

    // transitions and phase loads
    always_comb begin
        nxt     = state;
        ph_load = 1'b0;
        ph_len  = '0;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (state)
            S_PWRUP: begin
                if (pw_done)
                    nxt = S_IDLE;
            end
            S_IDLE: begin
                if (req) begin
                    accept  = 1'b1;
                    ph_load = 1'b1;
                    if (wr) begin
                        nxt    = S_WSETUP;
                        ph_len = CNT_W'(WSU_CYC);
                    end else begin
                        nxt    = S_READ;
                        ph_len = CNT_W'(RD_CYC);
                    end
                end
            end
            S_READ: begin
                if (ph_last) begin
                    capture = 1'b1;
                    nxt     = S_RTURN;
                    ph_load = 1'b1;
                    ph_len  = CNT_W'(HZ_CYC);
                end
            end
            S_RTURN: begin
                if (ph_last)
                    nxt = S_IDLE;
            end
            S_WSETUP: begin
                if (ph_last) begin
                    nxt     = S_WPULSE;
                    ph_load = 1'b1;
                    ph_len  = CNT_W'(WP_CYC);
                end
            end
            S_WPULSE: begin
                if (ph_last) begin
                    nxt     = S_WRECOV;
                    ph_load = 1'b1;
                    ph_len  = CNT_W'(REC_CYC);
                end
            end
            S_WRECOV: begin
                if (ph_last)
                    nxt = S_IDLE;
            end
            default: nxt = S_PWRUP;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        sel       = (state == S_READ) || (state == S_WSETUP) || (state == S_WPULSE);
        mem_ce_n  = !sel;
        mem_ce    = sel;
        mem_oe_n  = (state != S_READ);
        mem_we_n  = (state != S_WPULSE);
        mem_dq_oe = (state == S_WSETUP) || (state == S_WPULSE);
        ready     = (state == S_IDLE);
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    AST_PWRUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pw_done |-> (!ready && mem_ce_n && !mem_ce)); // R1
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe)); // R2
    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R7
    AST_READ_TO_DRIVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe); // R8
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce && $past(mem_ce)) |-> $stable(mem_addr)); // R10

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
    localparam int EXP_PWR  = 20000;
    localparam int EXP_RD   = 5;
    localparam int EXP_WP   = 4;
    localparam int EXP_HZ   = 2;
    localparam int EXP_REC  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [19:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] ram    [int];
    logic [7:0] shadow [int];
    logic [7:0] exp_q  [$];
    logic [19:0] exp_addr_q [$];

    always #5 clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // driver: one host transaction, expected read data pushed to the scoreboard
    task automatic issue(input bit w, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        if (w) shadow[int'(a)] = d;
        else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
            exp_addr_q.push_back(a);
        end
        @(negedge clk);
        req = 1'b0;
        addr = ~a; wdata = ~d;
    endtask

    // RAM model and monitor, sampled away from the active edge
    int  oe_run = 0, we_run = 0, gap = 1000, rec_run = 0;
    bit  in_rec = 1'b0;
    bit  p_sel = 1'b0, p_oe_n = 1'b1, p_we_n = 1'b1, p_rdv = 1'b0;
    logic [19:0] p_addr = '0;

    always @(negedge clk) begin
        bit s;
        s = !mem_ce_n && mem_ce;
        if (rst_n) begin
            if (!mem_oe_n && !mem_we_n) check(1'b0, "R3", 0, 1);
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R7", mem_oe_n, 1);
            if (ready)
                check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
                      "R2", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
            if (s && p_sel && mem_addr != p_addr) check(1'b0, "R10", mem_addr, p_addr);
            // read strobe length
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == EXP_RD, "R4", oe_run, EXP_RD);
                oe_run = 0;
                gap = 0;
            end
            // write strobe length and setup cycle
            if (!mem_we_n) begin
                if (p_we_n) check(p_sel && mem_dq_oe, "R6", {p_sel, mem_dq_oe}, 2'b11);
                if (!mem_oe_n || !s) check(1'b0, "R6", mem_oe_n, 1);
                ram[int'(mem_addr)] = mem_dq_out;
                we_run++;
            end else if (we_run > 0) begin
                check(we_run == EXP_WP, "R6", we_run, EXP_WP);
                we_run = 0;
                in_rec = 1'b1;
                rec_run = 0;
            end
            // recovery after a write
            if (in_rec) begin
                if (ready) begin
                    check(rec_run == EXP_REC, "R9", rec_run, EXP_REC);
                    in_rec = 1'b0;
                end else begin
                    if (s) check(1'b0, "R9", s, 0);
                    rec_run++;
                end
            end
            // turnaround after read
            if (mem_dq_oe && gap < 1000) begin
                check(gap >= EXP_HZ, "R8", gap, EXP_HZ);
                gap = 1000;
            end else if (gap < 1000 && mem_oe_n) gap++;
            // scoreboard
            if (rd_valid) begin
                check(!p_rdv, "R5", p_rdv, 0);
                check(!p_oe_n && mem_oe_n, "R5", {p_oe_n, mem_oe_n}, 2'b01);
                if (exp_q.size() == 0) check(1'b0, "R5", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    void'(exp_addr_q.pop_front());
                    check(rd_data == e, "R5", rd_data, e);
                end
            end
        end
        // RAM drives the bus only when selected, output-enabled and not writing
        if (s && !mem_oe_n && mem_we_n)
            mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'h00;
        if (s && !mem_oe_n && mem_we_n && p_sel && p_addr != mem_addr)
            check(1'b0, "R10", mem_addr, p_addr);
        p_sel = s; p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_rdv = rd_valid; p_addr = mem_addr;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        bit sel_seen;
        repeat (3) @(negedge clk);
        // reset state
        check(!ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
              "R1", {ready, mem_ce_n, mem_ce}, 3'b010);
        rst_n = 1'b1;
        n = 0; sel_seen = 1'b0;
        while (!ready && n < EXP_PWR + 10) begin
            @(negedge clk);
            n++;
            if (!mem_ce_n || mem_ce) sel_seen = 1'b1;
        end
        check(n == EXP_PWR, "R1", n, EXP_PWR);
        check(!sel_seen, "R1", sel_seen, 0);

        // corner addresses and data
        issue(1'b1, 20'h00000, 8'hA5);
        issue(1'b1, 20'hFFFFF, 8'h5A);
        issue(1'b1, 20'h12345, 8'h00);
        issue(1'b1, 20'h54321, 8'hFF);
        issue(1'b0, 20'h00000, 8'h00);
        issue(1'b0, 20'hFFFFF, 8'h00);
        issue(1'b0, 20'h12345, 8'h00);
        issue(1'b0, 20'h54321, 8'h00);
        issue(1'b0, 20'h00777, 8'h00);
        // overwrite then read back
        issue(1'b1, 20'h00000, 8'h3C);
        issue(1'b0, 20'h00000, 8'h00);
        // tight alternation of reads and writes
        for (int i = 0; i < 8; i++) begin
            issue(1'b1, 20'(i * 20'h1F3D + 20'h00100), 8'(i * 37 + 11));
            issue(1'b0, 20'(i * 20'h1F3D + 20'h00100), 8'h00);
            issue(1'b0, 20'hFFFFF, 8'h00);
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        finish_run();
    end

endmodule